// File: doc/BRIEF.md
# Up/Down Timer Base Counter with Hardware Triggers

The block is a 16-bit timer base. A clock prescaler turns the system clock into count ticks at a rate of one per 2^n cycles, and the counter moves one step per tick. The counter runs in one of two shapes. The first is a ramp that repeats in one direction. The second is a symmetric up-then-down wave whose turning points are the programmed top value and zero. At each wrap or turn the block emits one-cycle event pulses and sets sticky status bits. Each status bit can raise the interrupt line through its own enable.

Software controls the counter through plain configuration inputs and single-cycle strobes: period, direction, shape, prescaler code, stop-after-wrap, counter load, start and stop. Hardware can also start, stop or clear the counter. Three masks choose which qualified edges act:
- edges on a local trigger pin,
- an internal event strobe,
- and, for clear only, edges on a partner trigger and on a fed-back PWM level.

Asynchronous pins pass through a two-flop synchroniser before their edges are detected.

Top module: `tmr_base`

## Requirements
- R1: `div_sel_i` code n gives one count tick every 2^n clock cycles while running. The first tick falls 2^n cycles after start. Codes above 10 behave as code 10.
- R2: Ramp mode (`tri_mode_i`=0) with `dir_up_i`=1 counts up by one per tick. A tick taken while the count is at or above `period_i` returns the count to 0 and pulses `ovf_o`. This includes `period_i`=0, where every tick overflows.
- R3: Ramp mode with `dir_up_i`=0 counts down by one per tick. A tick taken at count 0 loads `period_i` and pulses `udf_o`.
- R4: Symmetric mode (`tri_mode_i`=1) starts counting upward after reset or a clear. A tick taken at the top reverses to downward, steps away from the top, and pulses `ovf_o` together with `peak_o`. A tick taken at 0 reverses to upward and pulses `udf_o` together with `valley_o`. `dir_o` shows the current direction (1 = up).
- R5: With `stop_on_wrap_i`=1, the tick that produces an overflow or underflow still updates the count, and the counter then stops running.
- R6: `ovf_flag_o` and `udf_flag_o` set on their events and hold until a one is written to `flag_clr_i` bit 0 or bit 1 respectively; a set in the same cycle wins. `irq_o` is high while an enabled flag (`ovf_ie_i`, `udf_ie_i`) is set.
- R7: `sw_start_i` sets running and `sw_stop_i` clears it; a stop wins over a start in the same cycle. While stopped the count holds.
- R8: `start_mask_i` and `stop_mask_i` use bit 0 = trigger rising edge, bit 1 = trigger falling edge, bit 2 = `evt_i` strobe. A trigger pin edge takes effect on the third clock edge after the pin changes. `evt_i` takes effect on the next edge. Edges whose mask bit is 0 have no effect.
- R9: A clear sets the count to 0, sets the symmetric direction to up, restarts the prescaler and leaves running unchanged. `clear_mask_i` uses bits 0 to 2 as in R8, bit 3/4 = partner trigger rising/falling, and bit 5/6 = feedback PWM rising/falling.
- R10: `cnt_load_i` writes `cnt_load_val_i` to the count on the next edge. A clear in the same cycle wins over a load, and a load wins over a tick.
- R11: `ovf_o`, `udf_o`, `peak_o` and `valley_o` are single-cycle pulses that appear with the count update that caused them; overflow and underflow never pulse together.
- R12: Reset gives count 0, stopped, direction up, all pulses and flags low, `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Top value of the count |
| dir_up_i | input | 1 | Ramp direction, 1 = up |
| tri_mode_i | input | 1 | 1 = symmetric up/down wave, 0 = ramp |
| div_sel_i | input | 4 | Prescaler code, divide by 2^code |
| stop_on_wrap_i | input | 1 | Stop after overflow or underflow |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| udf_ie_i | input | 1 | Underflow interrupt enable |
| cnt_load_i | input | 1 | Load strobe for the count |
| cnt_load_val_i | input | 16 | Value to load |
| sw_start_i | input | 1 | Software start strobe |
| sw_stop_i | input | 1 | Software stop strobe |
| start_mask_i | input | 3 | Hardware start source enables |
| stop_mask_i | input | 3 | Hardware stop source enables |
| clear_mask_i | input | 7 | Hardware clear source enables |
| trig_i | input | 1 | Asynchronous local trigger pin |
| evt_i | input | 1 | Synchronous internal event strobe |
| peer_trig_i | input | 1 | Asynchronous partner trigger pin |
| fb_pwm_i | input | 1 | Asynchronous fed-back PWM level |
| flag_clr_i | input | 2 | Write-one-to-clear, bit 0 overflow, bit 1 underflow |
| count_o | output | 16 | Current count |
| running_o | output | 1 | Counter running |
| dir_o | output | 1 | Current count direction, 1 = up |
| ovf_o | output | 1 | Overflow pulse |
| udf_o | output | 1 | Underflow pulse |
| peak_o | output | 1 | Symmetric-mode top pulse |
| valley_o | output | 1 | Symmetric-mode bottom pulse |
| ovf_flag_o | output | 1 | Sticky overflow status |
| udf_flag_o | output | 1 | Sticky underflow status |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on four assumptions about the inputs:
- `evt_i`, the software strobes and `flag_clr_i` are synchronous to `clk`.
- The prescaler code does not change on the cycle after a tick if the tick spacing is to hold.
- The pins are low when reset is released, so the synchronisers see no false edge.
- The shape, direction and period are set only while the counter is stopped.

The stimulus keeps within these assumptions in three ways. Every scenario begins with a reset. Configuration is changed only before a start. Every pin and strobe is driven on the falling clock edge, well clear of the rising edge that samples it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        MODE_RAMP = 1'b0,
        MODE_SYM  = 1'b1
    } cnt_mode_e;

    // Trigger source positions; the masks decode these bits.
    localparam int SRC_TRIG_RISE = 0;
    localparam int SRC_TRIG_FALL = 1;
    localparam int SRC_EVT       = 2;
    localparam int SRC_PEER_RISE = 3;
    localparam int SRC_PEER_FALL = 4;
    localparam int SRC_FB_RISE   = 5;
    localparam int SRC_FB_FALL   = 6;
    localparam int N_RUN_SRC     = 3;
    localparam int N_CLR_SRC     = 7;
    localparam int N_PINS        = 3;

    typedef struct packed {
        logic start;
        logic stop;
        logic clear;
    } trig_hit_t;

    function automatic int clamp_code(input int code, input int max_code);
        return (code > max_code) ? max_code : code;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[DEPTH-2:0], pin_i};
    end

    // Synchronised level versus the sample one clock older.
    assign rise_o =  shift_q[STAGES-1] & ~shift_q[STAGES];
    assign fall_o = ~shift_q[STAGES-1] &  shift_q[STAGES];
endmodule

// File: rtl/tmr_trig.sv
module tmr_trig import tmr_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_i,
    input  logic                 peer_i,
    input  logic                 fb_i,
    input  logic                 evt_i,
    input  logic [N_RUN_SRC-1:0] start_mask_i,
    input  logic [N_RUN_SRC-1:0] stop_mask_i,
    input  logic [N_CLR_SRC-1:0] clear_mask_i,
    output trig_hit_t            hit_o
);
    logic [N_PINS-1:0] pins;
    logic [N_PINS-1:0] rise;
    logic [N_PINS-1:0] fall;
    logic [N_CLR_SRC-1:0] src;

    assign pins = {fb_i, peer_i, trig_i};

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pins[p]),
            .rise_o(rise[p]),
            .fall_o(fall[p])
        );
    end

    always_comb begin
        src                = '0;
        src[SRC_TRIG_RISE] = rise[0];
        src[SRC_TRIG_FALL] = fall[0];
        src[SRC_EVT]       = evt_i;
        src[SRC_PEER_RISE] = rise[1];
        src[SRC_PEER_FALL] = fall[1];
        src[SRC_FB_RISE]   = rise[2];
        src[SRC_FB_FALL]   = fall[2];
    end

    assign hit_o.start = |(src[N_RUN_SRC-1:0] & start_mask_i);
    assign hit_o.stop  = |(src[N_RUN_SRC-1:0] & stop_mask_i);
    assign hit_o.clear = |(src & clear_mask_i);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale import tmr_pkg::*; #(
    parameter int SEL_W    = 4,
    parameter int MAX_CODE = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] code_i,
    output logic             tick_o
);
    localparam int PW = (MAX_CODE > 0) ? MAX_CODE : 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;
    int            code_c;

    always_comb begin
        code_c = clamp_code(int'(code_i), MAX_CODE);
        mask   = PW'((32'd1 << code_c) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i || !run_i) pre_q <= '0;
        else                            pre_q <= pre_q + 1'b1;
    end

    assign tick_o = run_i && ((pre_q & mask) == mask);

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && code_i != '0) |=> (!tick_o || code_i != $past(code_i)));
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             dir_up_i,
    input  cnt_mode_e        mode_i,
    input  logic             stop_on_wrap_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [1:0]       flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             dir_o,
    output logic             ovf_o,
    output logic             udf_o,
    output logic             peak_o,
    output logic             valley_o,
    output logic             ovf_flag_o,
    output logic             udf_flag_o
);
    logic [CNT_W-1:0] count_q, step_cnt;
    logic running_q, sym_up_q, step_up;
    logic ovf_q, udf_q, peak_q, valley_q, ovf_flag_q, udf_flag_q;
    logic up_now, at_top, at_bot, busy, ovf_ev, udf_ev;

    always_comb begin
        up_now   = (mode_i == MODE_SYM) ? sym_up_q : dir_up_i;
        at_top   = count_q >= period_i;
        at_bot   = count_q == '0;
        busy     = clr_i | load_i;
        ovf_ev   = tick_i & up_now & at_top & ~busy;
        udf_ev   = tick_i & ~up_now & at_bot & ~busy;
        step_cnt = count_q;
        step_up  = sym_up_q;
        if (mode_i == MODE_RAMP) begin
            if (dir_up_i) step_cnt = at_top ? '0 : count_q + 1'b1;
            else          step_cnt = at_bot ? period_i : count_q - 1'b1;
        end else if (sym_up_q) begin
            if (at_top) begin
                step_up  = 1'b0;
                step_cnt = at_bot ? count_q : count_q - 1'b1;
            end else begin
                step_cnt = count_q + 1'b1;
            end
        end else begin
            if (at_bot) begin
                step_up  = 1'b1;
                step_cnt = (period_i == '0) ? count_q : count_q + 1'b1;
            end else begin
                step_cnt = count_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q    <= '0;
            running_q  <= 1'b0;
            sym_up_q   <= 1'b1;
            ovf_q      <= 1'b0;
            udf_q      <= 1'b0;
            peak_q     <= 1'b0;
            valley_q   <= 1'b0;
            ovf_flag_q <= 1'b0;
            udf_flag_q <= 1'b0;
        end else begin
            if (clr_i) begin
                count_q  <= '0;
                sym_up_q <= 1'b1;
            end else if (load_i) begin
                count_q <= load_val_i;
            end else if (tick_i) begin
                count_q  <= step_cnt;
                sym_up_q <= step_up;
            end
            if (mode_i == MODE_RAMP) sym_up_q <= 1'b1;
            running_q  <= (running_q | start_i) & ~stop_i
                          & ~(stop_on_wrap_i & (ovf_ev | udf_ev));
            ovf_q      <= ovf_ev;
            udf_q      <= udf_ev;
            peak_q     <= ovf_ev & (mode_i == MODE_SYM);
            valley_q   <= udf_ev & (mode_i == MODE_SYM);
            ovf_flag_q <= ovf_ev | (ovf_flag_q & ~flag_clr_i[0]);
            udf_flag_q <= udf_ev | (udf_flag_q & ~flag_clr_i[1]);
        end
    end

    assign count_o    = count_q;
    assign running_o  = running_q;
    assign dir_o      = up_now;
    assign ovf_o      = ovf_q;
    assign udf_o      = udf_q;
    assign peak_o     = peak_q;
    assign valley_o   = valley_q;
    assign ovf_flag_o = ovf_flag_q;
    assign udf_flag_o = udf_flag_q;

    // R11
    ovf_udf_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && udf_q));
    // R4
    peak_with_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (peak_q |-> ovf_q) and (valley_q |-> udf_q));
    // R5
    wrap_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_on_wrap_i && (ovf_ev || udf_ev)) |=> !running_q);
    // R6
    ovf_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag_q) |-> ovf_q);
    // R6
    udf_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(udf_flag_q) |-> udf_q);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !clr_i && !load_i) |=> $stable(count_q));
endmodule

// File: rtl/tmr_base.sv
module tmr_base import tmr_pkg::*; #(
    parameter int CNT_W        = 16,
    parameter int DIV_SEL_W    = 4,
    parameter int MAX_DIV_CODE = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     period_i,
    input  logic                 dir_up_i,
    input  logic                 tri_mode_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    input  logic                 stop_on_wrap_i,
    input  logic                 ovf_ie_i,
    input  logic                 udf_ie_i,
    input  logic                 cnt_load_i,
    input  logic [CNT_W-1:0]     cnt_load_val_i,
    input  logic                 sw_start_i,
    input  logic                 sw_stop_i,
    input  logic [2:0]           start_mask_i,
    input  logic [2:0]           stop_mask_i,
    input  logic [6:0]           clear_mask_i,
    input  logic                 trig_i,
    input  logic                 evt_i,
    input  logic                 peer_trig_i,
    input  logic                 fb_pwm_i,
    input  logic [1:0]           flag_clr_i,
    output logic [CNT_W-1:0]     count_o,
    output logic                 running_o,
    output logic                 dir_o,
    output logic                 ovf_o,
    output logic                 udf_o,
    output logic                 peak_o,
    output logic                 valley_o,
    output logic                 ovf_flag_o,
    output logic                 udf_flag_o,
    output logic                 irq_o
);
    trig_hit_t hit;
    logic      tick;
    logic      running;

    tmr_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_i),
        .peer_i      (peer_trig_i),
        .fb_i        (fb_pwm_i),
        .evt_i       (evt_i),
        .start_mask_i(start_mask_i),
        .stop_mask_i (stop_mask_i),
        .clear_mask_i(clear_mask_i),
        .hit_o       (hit)
    );

    tmr_prescale #(.SEL_W(DIV_SEL_W), .MAX_CODE(MAX_DIV_CODE)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run_i    (running),
        .restart_i(hit.clear),
        .code_i   (div_sel_i),
        .tick_o   (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk           (clk),
        .rst           (rst),
        .tick_i        (tick),
        .period_i      (period_i),
        .dir_up_i      (dir_up_i),
        .mode_i        (cnt_mode_e'(tri_mode_i)),
        .stop_on_wrap_i(stop_on_wrap_i),
        .load_i        (cnt_load_i),
        .load_val_i    (cnt_load_val_i),
        .clr_i         (hit.clear),
        .start_i       (sw_start_i | hit.start),
        .stop_i        (sw_stop_i | hit.stop),
        .flag_clr_i    (flag_clr_i),
        .count_o       (count_o),
        .running_o     (running),
        .dir_o         (dir_o),
        .ovf_o         (ovf_o),
        .udf_o         (udf_o),
        .peak_o        (peak_o),
        .valley_o      (valley_o),
        .ovf_flag_o    (ovf_flag_o),
        .udf_flag_o    (udf_flag_o)
    );

    assign running_o = running;
    assign irq_o     = (ovf_flag_o & ovf_ie_i) | (udf_flag_o & udf_ie_i);
endmodule

// File: tb/tb_tmr_base.sv
`timescale 1ns/1ps
module tb_tmr_base;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] period_i = '0;
    logic        dir_up_i = 1'b1, tri_mode_i = 1'b0;
    logic [3:0]  div_sel_i = '0;
    logic        stop_on_wrap_i = 1'b0, ovf_ie_i = 1'b0, udf_ie_i = 1'b0;
    logic        cnt_load_i = 1'b0;
    logic [15:0] cnt_load_val_i = '0;
    logic        sw_start_i = 1'b0, sw_stop_i = 1'b0;
    logic [2:0]  start_mask_i = '0, stop_mask_i = '0;
    logic [6:0]  clear_mask_i = '0;
    logic        trig_i = 1'b0, evt_i = 1'b0, peer_trig_i = 1'b0, fb_pwm_i = 1'b0;
    logic [1:0]  flag_clr_i = '0;
    logic [15:0] count_o;
    logic        running_o, dir_o, ovf_o, udf_o, peak_o, valley_o;
    logic        ovf_flag_o, udf_flag_o, irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] held;

    always #5 clk = ~clk;

    tmr_base dut (.*);

    typedef struct packed {
        logic        sym;
        logic        up;
        logic [3:0]  div;
        logic [15:0] per;
        logic [15:0] cycles;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
        logic        exp_udf;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 4'd0,  16'd9,   16'd25,   16'd5, 1'b1, 1'b0},
        '{1'b0, 1'b1, 4'd2,  16'd100, 16'd40,   16'd10, 1'b0, 1'b0},
        '{1'b0, 1'b0, 4'd0,  16'd7,   16'd5,    16'd3, 1'b0, 1'b1},
        '{1'b0, 1'b0, 4'd1,  16'd3,   16'd20,   16'd2, 1'b0, 1'b1},
        '{1'b1, 1'b1, 4'd0,  16'd5,   16'd7,    16'd3, 1'b1, 1'b0},
        '{1'b1, 1'b1, 4'd0,  16'd4,   16'd9,    16'd1, 1'b1, 1'b1},
        '{1'b1, 1'b1, 4'd3,  16'd2,   16'd30,   16'd1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 4'd10, 16'd3,   16'd3000, 16'd2, 1'b0, 1'b0},
        '{1'b0, 1'b1, 4'd15, 16'd100, 16'd2100, 16'd2, 1'b0, 1'b0},
        '{1'b0, 1'b1, 4'd0,  16'd0,   16'd3,    16'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        period_i = '0; dir_up_i = 1'b1; tri_mode_i = 1'b0; div_sel_i = '0;
        stop_on_wrap_i = 1'b0; ovf_ie_i = 1'b0; udf_ie_i = 1'b0;
        cnt_load_i = 1'b0; sw_start_i = 1'b0; sw_stop_i = 1'b0;
        start_mask_i = '0; stop_mask_i = '0; clear_mask_i = '0;
        trig_i = 1'b0; evt_i = 1'b0; peer_trig_i = 1'b0; fb_pwm_i = 1'b0;
        flag_clr_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start_pulse();
        @(negedge clk) sw_start_i = 1'b1;
        @(negedge clk) sw_start_i = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R12: reset state
        do_reset();
        @(negedge clk);
        chk("R12 count", count_o, 0);
        chk("R12 running", running_o, 0);
        chk("R12 dir", dir_o, 1);
        chk("R12 flags", {ovf_flag_o, udf_flag_o, ovf_o, udf_o}, 0);
        chk("R12 irq", irq_o, 0);

        // Table walk: R1 prescaler, R2/R3 ramp, R4 symmetric, R6 flags
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            tri_mode_i = VECS[i].sym;
            dir_up_i   = VECS[i].up;
            div_sel_i  = VECS[i].div;
            period_i   = VECS[i].per;
            start_pulse();
            repeat (int'(VECS[i].cycles)) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R1/R2/R3/R4 vec%0d count", i), count_o, VECS[i].exp_cnt);
            chk($sformatf("R6 vec%0d ovf flag", i), ovf_flag_o, VECS[i].exp_ovf);
            chk($sformatf("R6 vec%0d udf flag", i), udf_flag_o, VECS[i].exp_udf);
        end

        // R4 / R11: peak and valley pulse timing, top 2
        do_reset();
        tri_mode_i = 1'b1; period_i = 16'd2;
        start_pulse();
        edges(3);
        chk("R4 peak count", count_o, 1);
        chk("R11 peak pulses", {peak_o, ovf_o, valley_o, udf_o}, 4'b1100);
        chk("R4 dir down", dir_o, 0);
        edges(1);
        chk("R11 pulse drops", {peak_o, ovf_o}, 0);
        chk("R4 count at bottom", count_o, 0);
        edges(1);
        chk("R11 valley pulses", {peak_o, ovf_o, valley_o, udf_o}, 4'b0011);
        chk("R4 dir up", dir_o, 1);
        chk("R4 count after valley", count_o, 1);

        // R5: stop after wrap
        do_reset();
        period_i = 16'd3; stop_on_wrap_i = 1'b1;
        start_pulse();
        edges(4);
        chk("R5 stopped", running_o, 0);
        chk("R5 wrapped count", count_o, 0);
        chk("R5 ovf pulse", ovf_o, 1);
        edges(5);
        chk("R5 count held", count_o, 0);

        // R6: interrupt and write-one-to-clear
        ovf_ie_i = 1'b1;
        @(negedge clk);
        chk("R6 irq", irq_o, 1);
        flag_clr_i = 2'b10;
        @(negedge clk) flag_clr_i = 2'b00;
        chk("R6 wrong clear bit", ovf_flag_o, 1);
        flag_clr_i = 2'b01;
        @(negedge clk) flag_clr_i = 2'b00;
        chk("R6 flag cleared", ovf_flag_o, 0);
        chk("R6 irq cleared", irq_o, 0);

        // R10: load, and clear beats load
        do_reset();
        cnt_load_val_i = 16'h1234; cnt_load_i = 1'b1;
        @(negedge clk) cnt_load_i = 1'b0;
        chk("R10 load", count_o, 16'h1234);
        clear_mask_i = 7'b0000100;
        cnt_load_i = 1'b1; evt_i = 1'b1;
        @(negedge clk) begin cnt_load_i = 1'b0; evt_i = 1'b0; end
        chk("R10 clear over load", count_o, 0);

        // R7: stop wins over start; stop freezes count
        do_reset();
        period_i = 16'd500;
        sw_start_i = 1'b1; sw_stop_i = 1'b1;
        @(negedge clk) begin sw_start_i = 1'b0; sw_stop_i = 1'b0; end
        chk("R7 stop wins", running_o, 0);
        start_pulse();
        edges(3);
        chk("R7 running count", count_o, 3);
        sw_stop_i = 1'b1;
        @(negedge clk) sw_stop_i = 1'b0;
        chk("R7 stopped", running_o, 0);
        held = count_o;
        edges(4);
        chk("R7 count held", count_o, held);

        // R8: hardware start by event, stop by trigger falling edge
        do_reset();
        period_i = 16'd1000;
        start_mask_i = 3'b100; stop_mask_i = 3'b010;
        evt_i = 1'b1;
        @(negedge clk) evt_i = 1'b0;
        chk("R8 event start", running_o, 1);
        trig_i = 1'b1;
        edges(4);
        chk("R8 rising edge ignored", running_o, 1);
        trig_i = 1'b0;
        edges(2);
        chk("R8 not yet stopped", running_o, 1);
        edges(1);
        chk("R8 falling edge stop", running_o, 0);
        held = count_o;
        edges(3);
        chk("R8 count frozen", count_o, held);

        // R9: clear from partner falling edge and feedback rising edge
        do_reset();
        period_i = 16'd1000; clear_mask_i = 7'b0010000;
        start_pulse();
        peer_trig_i = 1'b1;
        edges(5);
        chk("R9 partner rise ignored", count_o, 5);
        peer_trig_i = 1'b0;
        edges(3);
        chk("R9 partner fall clear", count_o, 0);
        chk("R9 still running", running_o, 1);
        clear_mask_i = 7'b0100000;
        edges(2);
        fb_pwm_i = 1'b1;
        edges(3);
        chk("R9 feedback rise clear", count_o, 0);

        // R9: clear in symmetric mode restores upward direction
        do_reset();
        tri_mode_i = 1'b1; period_i = 16'd3; clear_mask_i = 7'b0000100;
        start_pulse();
        edges(4);
        chk("R4 heading down", {count_o, dir_o}, {16'd2, 1'b0});
        evt_i = 1'b1;
        @(negedge clk) evt_i = 1'b0;
        chk("R9 clear count", count_o, 0);
        chk("R9 clear dir up", dir_o, 1);
        chk("R9 clear keeps running", running_o, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule